// File: doc/BRIEF.md
# Trigger Event Packet Formatter

This block turns each accepted trigger into one fixed-length event record of ten 32-bit words. It sends those words, one at a time, over a valid/ready word stream toward a datagram transmitter. On the trigger cycle it copies the event's fields into its own registers. These fields are the timestamp, the three trigger counters, the masked NIM and eSATA input vectors, and the signals that make up the trigger bitmap. Later changes on those inputs therefore cannot alter a record that is already in flight.

Each record opens with a free-running packet sequence number. A tagged header follows it, then the seven payload words, then a tagged footer. The header and the footer both carry the low 28 bits of the accepted-trigger count, so a receiver can pair them. The bitmap word is assembled inside the block from its component flags, the registered coincidence bits and the low byte of the multiplicity.

A controller FSM has five states. The states are `ST_IDLE`, `ST_SEQ` (word 0), `ST_HDR` (word 1), `ST_BODY` (words 2 to 8, walked by an index) and `ST_FTR` (word 9). The transitions are:
- trigger admit: `ST_IDLE` to `ST_SEQ`, taken when a trigger arrives with emission enabled.
- sequence sent: `ST_SEQ` to `ST_HDR`.
- header sent: `ST_HDR` to `ST_BODY`.
- body done: `ST_BODY` to `ST_FTR`, taken on the handshake of the last body word.
- footer sent: `ST_FTR` to `ST_IDLE`.

Every transition except trigger admit happens only on a cycle where valid and ready are both high.

Top module: `trig_pkt_fmt`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` and `out_last` are 0. The first record after reset carries 0 in word 0.
- R2: Word 0 holds the packet sequence number. It increases by exactly 1 for each record whose footer is transferred.
- R3: Word 1 is the header: bits 31:28 hold 0x8 and bits 27:0 hold bits 27:0 of the accepted-trigger count.
- R4: Words 2, 3, 4 and 5 are, in that order, the trigger timestamp, the accepted-trigger count, the trigger-input count and the pulser-trigger count.
- R5: Word 6 is the bitmap, with these fields:
  - bit 0: 16-channel ADC OR
  - bit 1: 32-channel ADC OR
  - bit 2: overall ADC OR
  - bit 3: eSATA/NIM OR
  - bit 4: top coincidence
  - bit 5: bottom coincidence
  - bit 6: combined coincidence
  - bit 7: constant 0
  - bits 23:8: the 16 coincidence bits
  - bits 31:24: bits 7:0 of the multiplicity input
- R6: Word 7 is the masked NIM vector and word 8 is the masked eSATA vector, each 32 bits wide.
- R7: Word 9 is the footer: bits 31:28 hold 0x9 and bits 27:0 are the same as the header's. `out_last` is 1 with the footer and with no other word.
- R8: A trigger whose `udp_enable` is 0 in its own cycle starts no record and does not advance the sequence number.
- R9: Every field is taken from the trigger cycle. Input changes after that cycle do not alter the record.
- R10: A trigger that arrives while a record is streaming, including during the footer's transfer cycle, is dropped. It produces no record and does not advance the sequence number.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R12: `out_valid` rises on the cycle after an admitted trigger. A trigger in the first cycle after a footer transfer is admitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_accept | input | 1 | One-cycle accepted-trigger strobe |
| udp_enable | input | 1 | Emission enable configuration bit |
| trig_ts | input | 32 | Latched trigger timestamp |
| cnt_accepted | input | 32 | Accepted-trigger counter |
| cnt_input | input | 32 | Trigger-input counter |
| cnt_pulser | input | 32 | Pulser-trigger counter |
| or_adc16 | input | 1 | 16-channel ADC grand OR |
| or_adc32 | input | 1 | 32-channel ADC grand OR |
| or_adc | input | 1 | Overall ADC grand OR |
| or_esata_nim | input | 1 | eSATA/NIM grand OR |
| coinc_top | input | 1 | Top coincidence |
| coinc_bot | input | 1 | Bottom coincidence |
| coinc_all | input | 1 | Combined coincidence |
| coinc_bits | input | 16 | Registered coincidence bits |
| mult | input | 16 | Multiplicity (low 8 bits reported) |
| nim_bits | input | 32 | Masked NIM inputs, 2 per ADC |
| esata_bits | input | 32 | Masked eSATA inputs, 2 per ADC |
| out_valid | output | 1 | Word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Stream word |
| out_last | output | 1 | Marks the footer word |

## Verification
The bench sends a sweep of records and computes each expected word from the inputs it drove. The first seven records walk a single one across the seven bitmap flags, which tells apart any swap or shift among the low bitmap positions. Later records use scrambled values, with multiplicity high bytes that differ from the low bytes, to separate the 28-bit header truncation and the byte selection of the multiplicity.

Each record is drained under one of three ready patterns: always ready, alternating, or pseudo-random. These show whether a word advances without a handshake or changes while stalled. Between cycles the bench scrambles every field input, and it injects triggers into streaming records (some during the footer) and also with emission disabled. These cases separate a live-input path from a snapshot, and a dropped trigger from one that is admitted or counted.

// File: rtl/trig_pkt_pkg.sv
package trig_pkt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEQ  = 3'd1,
        ST_HDR  = 3'd2,
        ST_BODY = 3'd3,
        ST_FTR  = 3'd4
    } fmt_state_t;

    localparam int TAG_W     = 4;
    localparam logic [TAG_W-1:0] TAG_HEAD = 4'h8;
    localparam logic [TAG_W-1:0] TAG_TAIL = 4'h9;

    // body word slots, in stream order
    localparam int SLOT_TS    = 0;
    localparam int SLOT_ACC   = 1;
    localparam int SLOT_IN    = 2;
    localparam int SLOT_PULS  = 3;
    localparam int SLOT_BMAP  = 4;
    localparam int SLOT_NIM   = 5;
    localparam int SLOT_ESATA = 6;
    localparam int BODY_WORDS = 7;
    localparam int PKT_WORDS  = BODY_WORDS + 3;

endpackage

// File: rtl/trig_bitmap_pack.sv
module trig_bitmap_pack #(
    parameter int COINC_W   = 16,
    parameter int MULT_W    = 16,
    parameter int MULT_KEEP = 8,
    localparam int FLAG_W   = 8,
    localparam int BMAP_W   = FLAG_W + COINC_W + MULT_KEEP
) (
    input  logic               or_adc16,
    input  logic               or_adc32,
    input  logic               or_adc,
    input  logic               or_esata_nim,
    input  logic               coinc_top,
    input  logic               coinc_bot,
    input  logic               coinc_all,
    input  logic [COINC_W-1:0] coinc_bits,
    input  logic [MULT_W-1:0]  mult,
    output logic [BMAP_W-1:0]  bitmap
);

    logic [FLAG_W-1:0] flags;

    // flag positions are decoded downstream; bit 7 is reserved as zero
    always_comb begin
        flags    = '0;
        flags[0] = or_adc16;
        flags[1] = or_adc32;
        flags[2] = or_adc;
        flags[3] = or_esata_nim;
        flags[4] = coinc_top;
        flags[5] = coinc_bot;
        flags[6] = coinc_all;
    end

    assign bitmap = {mult[MULT_KEEP-1:0], coinc_bits, flags};

endmodule

// File: rtl/trig_field_latch.sv
module trig_field_latch #(
    parameter int WORD_W = 32,
    parameter int N      = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic [N*WORD_W-1:0] fields_in,
    output logic [N*WORD_W-1:0] fields_q
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (cap_en) begin
                slot_q <= fields_in[g*WORD_W +: WORD_W];
            end
        end

        assign fields_q[g*WORD_W +: WORD_W] = slot_q;
    end

endmodule

// File: rtl/trig_word_seq.sv
module trig_word_seq
    import trig_pkt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SEQ_W  = 32,
    localparam int CNT_W = WORD_W - TAG_W,
    localparam int IDX_W = $clog2(BODY_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         trig_accept,
    input  logic                         udp_enable,
    input  logic [BODY_WORDS*WORD_W-1:0] body_q,
    output logic                         cap_en,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [WORD_W-1:0]            out_data,
    output logic                         out_last
);

    fmt_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [SEQ_W-1:0] seq_q;
    logic             xfer;
    logic             body_end;
    logic [CNT_W-1:0] tag_cnt;

    assign xfer     = out_valid && out_ready;
    assign body_end = (idx_q == IDX_W'(BODY_WORDS - 1));
    assign tag_cnt  = body_q[SLOT_ACC*WORD_W +: CNT_W];
    assign cap_en   = (state_q == ST_IDLE) && trig_accept && udp_enable;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trig_accept && udp_enable) state_d = ST_SEQ;
            ST_SEQ:  if (out_ready)                 state_d = ST_HDR;
            ST_HDR:  if (out_ready)                 state_d = ST_BODY;
            ST_BODY: if (out_ready && body_end)     state_d = ST_FTR;
            ST_FTR:  if (out_ready)                 state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // body word index and sequence number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            seq_q <= '0;
        end else begin
            if (state_q == ST_HDR) begin
                idx_q <= '0;
            end else if (state_q == ST_BODY && xfer && !body_end) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_FTR && xfer) begin
                seq_q <= seq_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_data  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEQ: begin
                out_valid = 1'b1;
                out_data  = WORD_W'(seq_q);
            end
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = {TAG_HEAD, tag_cnt};
            end
            ST_BODY: begin
                out_valid = 1'b1;
                out_data  = body_q[idx_q*WORD_W +: WORD_W];
            end
            ST_FTR: begin
                out_valid = 1'b1;
                out_last  = 1'b1;
                out_data  = {TAG_TAIL, tag_cnt};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/trig_pkt_fmt.sv
module trig_pkt_fmt
    import trig_pkt_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int SEQ_W     = 32,
    parameter int COINC_W   = 16,
    parameter int MULT_W    = 16,
    parameter int MULT_KEEP = 8,
    parameter int ADC_N     = 16,
    localparam int EDGE_W   = 2 * ADC_N,
    localparam int BMAP_W   = 8 + COINC_W + MULT_KEEP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_accept,
    input  logic               udp_enable,
    input  logic [WORD_W-1:0]  trig_ts,
    input  logic [WORD_W-1:0]  cnt_accepted,
    input  logic [WORD_W-1:0]  cnt_input,
    input  logic [WORD_W-1:0]  cnt_pulser,
    input  logic               or_adc16,
    input  logic               or_adc32,
    input  logic               or_adc,
    input  logic               or_esata_nim,
    input  logic               coinc_top,
    input  logic               coinc_bot,
    input  logic               coinc_all,
    input  logic [COINC_W-1:0] coinc_bits,
    input  logic [MULT_W-1:0]  mult,
    input  logic [EDGE_W-1:0]  nim_bits,
    input  logic [EDGE_W-1:0]  esata_bits,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_last
);

    logic [BMAP_W-1:0]            bitmap;
    logic [BODY_WORDS*WORD_W-1:0] body_in;
    logic [BODY_WORDS*WORD_W-1:0] body_q;
    logic                         cap_en;

    trig_bitmap_pack #(
        .COINC_W  (COINC_W),
        .MULT_W   (MULT_W),
        .MULT_KEEP(MULT_KEEP)
    ) bmap_i (
        .or_adc16    (or_adc16),
        .or_adc32    (or_adc32),
        .or_adc      (or_adc),
        .or_esata_nim(or_esata_nim),
        .coinc_top   (coinc_top),
        .coinc_bot   (coinc_bot),
        .coinc_all   (coinc_all),
        .coinc_bits  (coinc_bits),
        .mult        (mult),
        .bitmap      (bitmap)
    );

    always_comb begin
        body_in = '0;
        body_in[SLOT_TS*WORD_W    +: WORD_W] = trig_ts;
        body_in[SLOT_ACC*WORD_W   +: WORD_W] = cnt_accepted;
        body_in[SLOT_IN*WORD_W    +: WORD_W] = cnt_input;
        body_in[SLOT_PULS*WORD_W  +: WORD_W] = cnt_pulser;
        body_in[SLOT_BMAP*WORD_W  +: WORD_W] = WORD_W'(bitmap);
        body_in[SLOT_NIM*WORD_W   +: WORD_W] = WORD_W'(nim_bits);
        body_in[SLOT_ESATA*WORD_W +: WORD_W] = WORD_W'(esata_bits);
    end

    trig_field_latch #(
        .WORD_W(WORD_W),
        .N     (BODY_WORDS)
    ) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .fields_in(body_in),
        .fields_q (body_q)
    );

    trig_word_seq #(
        .WORD_W(WORD_W),
        .SEQ_W (SEQ_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_accept(trig_accept),
        .udp_enable (udp_enable),
        .body_q     (body_q),
        .cap_en     (cap_en),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last)
    );

endmodule

// File: rtl/trig_pkt_fmt_chk.sv
module trig_pkt_fmt_chk #(
    parameter int WORD_W = 32,
    parameter int SEQ_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_accept,
    input logic              udp_enable,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_last
);

    localparam int NWORDS = trig_pkt_pkg::PKT_WORDS;
    localparam int CW     = WORD_W - 4;

    logic [3:0]       widx_q;
    logic [CW-1:0]    hdr_q;
    logic [SEQ_W-1:0] pkts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx_q <= '0;
            hdr_q  <= '0;
            pkts_q <= '0;
        end else if (out_valid && out_ready) begin
            if (widx_q == 4'(NWORDS - 1)) begin
                widx_q <= '0;
                pkts_q <= pkts_q + 1'b1;
            end else begin
                widx_q <= widx_q + 1'b1;
            end
            if (widx_q == 4'd1) hdr_q <= out_data[CW-1:0];
        end
    end

    AST_RST_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_last); // R1
    AST_SEQ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && widx_q == 4'd0 |-> out_data == WORD_W'(pkts_q)); // R2
    AST_HEAD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && widx_q == 4'd1 |-> out_data[WORD_W-1 -: 4] == 4'h8); // R3
    AST_BMAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && widx_q == 4'd6 |-> !out_data[7]); // R5
    AST_TAIL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> out_data[WORD_W-1 -: 4] == 4'h9 && out_data[CW-1:0] == hdr_q); // R7
    AST_LAST_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_last == (widx_q == 4'(NWORDS - 1))); // R7
    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && !udp_enable |=> !out_valid); // R8
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R11
    AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && trig_accept && udp_enable |=> out_valid); // R12

endmodule

bind trig_pkt_fmt trig_pkt_fmt_chk #(
    .WORD_W(WORD_W),
    .SEQ_W (SEQ_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_accept(trig_accept),
    .udp_enable (udp_enable),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last)
);

// File: tb/trig_pkt_fmt_tb_top.sv
module trig_pkt_fmt_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trig_accept, udp_enable;
    logic [31:0] trig_ts, cnt_accepted, cnt_input, cnt_pulser;
    logic        or_adc16, or_adc32, or_adc, or_esata_nim;
    logic        coinc_top, coinc_bot, coinc_all;
    logic [15:0] coinc_bits, mult;
    logic [31:0] nim_bits, esata_bits;
    logic        out_valid, out_ready, out_last;
    logic [31:0] out_data;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;
    logic [31:0] rng = 32'h1234_5679;
    logic [31:0] pkt_no = 0;
    logic [31:0] exp_w [10];

    always #4 clk = ~clk;

    trig_pkt_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .trig_accept(trig_accept), .udp_enable(udp_enable),
        .trig_ts(trig_ts), .cnt_accepted(cnt_accepted), .cnt_input(cnt_input),
        .cnt_pulser(cnt_pulser), .or_adc16(or_adc16), .or_adc32(or_adc32),
        .or_adc(or_adc), .or_esata_nim(or_esata_nim), .coinc_top(coinc_top),
        .coinc_bot(coinc_bot), .coinc_all(coinc_all), .coinc_bits(coinc_bits),
        .mult(mult), .nim_bits(nim_bits), .esata_bits(esata_bits),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic string word_req(input int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2, 3, 4, 5: return "R4";
            6: return "R5";
            7, 8: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic scramble();
        rng = next_rng(rng); trig_ts = rng;
        rng = next_rng(rng); cnt_accepted = rng;
        rng = next_rng(rng); cnt_input = rng;
        rng = next_rng(rng); cnt_pulser = rng;
        rng = next_rng(rng); nim_bits = rng;
        rng = next_rng(rng); esata_bits = rng;
        rng = next_rng(rng); coinc_bits = rng[15:0]; mult = rng[31:16];
        {or_adc16, or_adc32, or_adc, or_esata_nim, coinc_top, coinc_bot, coinc_all} = rng[6:0];
    endtask

    // Trigger with the given flag pattern; expected words are computed here (R9: inputs scrambled afterwards).
    task automatic fire(input int p, input bit en);
        logic [6:0] fl;
        @(negedge clk);
        scramble();
        fl = (p < 7) ? 7'(1 << p) : rng[12:6];
        {coinc_all, coinc_bot, coinc_top, or_esata_nim, or_adc, or_adc32, or_adc16} = fl;
        if (p >= 7) mult = {~mult[7:0], mult[7:0]};
        trig_accept = 1'b1;
        udp_enable  = en;
        exp_w[0] = pkt_no;
        exp_w[1] = {4'h8, cnt_accepted[27:0]};
        exp_w[2] = trig_ts;
        exp_w[3] = cnt_accepted;
        exp_w[4] = cnt_input;
        exp_w[5] = cnt_pulser;
        exp_w[6] = {mult[7:0], coinc_bits, 1'b0, fl};
        exp_w[7] = nim_bits;
        exp_w[8] = esata_bits;
        exp_w[9] = {4'h9, cnt_accepted[27:0]};
        @(negedge clk);
        trig_accept = 1'b0;
        udp_enable  = 1'b1;
        scramble();
        #1;
        check("R12 valid after trigger", {31'd0, out_valid}, {31'd0, en});
    endtask

    task automatic expect_idle(input string req, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            #1;
            check(req, {31'd0, out_valid}, 32'd0);
        end
    endtask

    // Drain one record; mode 0 always ready, 1 alternating, 2 random. inj >= 0: trigger during that word.
    task automatic drain(input int mode, input int inj);
        int  idx = 0;
        int  cyc = 0;
        bit  held = 0;
        logic [31:0] hd;
        logic hl;
        bit rdy;
        while (idx < 10) begin
            @(negedge clk);
            cyc++;
            rng = next_rng(rng);
            rdy = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : rng[3];
            out_ready   = rdy;
            trig_accept = (idx == inj);
            scramble();
            #1;
            if (held) begin
                check("R11 held data", out_data, hd);
                check("R11 held last", {31'd0, out_last}, {31'd0, hl});
                held = 0;
            end
            check("R12 valid mid-record", {31'd0, out_valid}, 32'd1);
            if (out_valid && rdy) begin
                check(word_req(idx), out_data, exp_w[idx]);
                check("R7 last flag", {31'd0, out_last}, {31'd0, (idx == 9)});
                idx++;
            end else if (out_valid) begin
                held = 1; hd = out_data; hl = out_last;
            end
        end
        pkt_no++;
        @(negedge clk);
        trig_accept = 1'b0;
        out_ready   = 1'b0;
        #1;
        check(inj >= 0 ? "R10 no record from dropped trigger" : "R12 idle after footer",
              {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; trig_accept = 1'b0; udp_enable = 1'b1; out_ready = 1'b0;
        scramble();
        repeat (3) @(negedge clk);
        #1;
        check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1 last in reset", {31'd0, out_last}, 32'd0);
        rst_n = 1'b1;
        expect_idle("R1 idle after reset", 2);

        // disabled trigger: no record, counter unchanged (R8)
        fire(0, 1'b0);
        expect_idle("R8 no record when disabled", 4);

        for (int p = 0; p < 24; p++) begin
            fire(p, 1'b1);
            drain(p % 3, (p % 4 == 1) ? 9 : (p % 4 == 3) ? (p % 9) : -1);
            if (p % 5 == 4) begin
                fire(p, 1'b0);
                expect_idle("R8 no record when disabled", 3);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule